// File: doc/BRIEF.md
# Semaphore Poll Min-Reduce Unit

This unit speeds up polling of a group of 32-bit semaphore words. A command names a base address, a word count between 1 and 16, an operation code, a write-back base address and a destination general-purpose register. The unit reads the words in order over a single-outstanding memory port and keeps a running unsigned minimum, seeded by the first word. When the final minimum is nonzero, it writes that value to each of the word slots at the write-back base and to the chosen register. A zero minimum leaves memory and the register untouched.

A command that asks for any operation other than minimum, or for a count outside 1..16, is rejected. It makes no memory access and completes at once with an error flag. Each accepted command also carries an opaque synchronisation descriptor, which is handed on unchanged to an external wait/update sequencer. The result register file can be read through a combinational read port.

Top module: `sem_poll_minred`

## Requirements
- R1: Reads go to base+0, base+1, ... base+(n-1) in ascending order. Each read is a one-cycle request with `mem_we`=0, and no further request is made until its data has returned on `mem_rvalid`.
- R2: Operation code 0 is minimum. Codes 1, 2 and 3 are rejected: `done` rises with `done_err`=1 and no memory access is made.
- R3: A count of 0, or a count greater than 16, is rejected the same way: no memory access, and `done` with `done_err`=1 in the first cycle after acceptance.
- R4: The result is the unsigned minimum of the words read. The first word read seeds the accumulator.
- R5: After the last read has returned, a nonzero result is written (`mem_we`=1) to wb+0 ... wb+(n-1), one word per cycle, in ascending order.
- R6: A nonzero result is also stored in general-purpose register `cmd_dst`, which can then be read on `gpr_rd_data` when `gpr_rd_sel` selects it.
- R7: A zero result causes no write, leaves every register unchanged and gives `done_wrote`=0.
- R8: `done` is a one-cycle pulse. It comes in cycle 3n+1 after acceptance when the result is nonzero and in cycle 2n+1 when it is zero (with a one-cycle read latency). `done_err` and `done_wrote` are valid together with it.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: In the cycle after acceptance, `seq_valid` pulses for one cycle and `seq_desc` carries the `sync_in` value that was sampled at acceptance.
- R11: After reset the unit is idle, makes no memory request, shows no `done` or `seq_valid`, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmd_count | input | 5 | Number of words to poll |
| cmd_op | input | 2 | Reduction code (0 = minimum) |
| cmd_addr | input | 16 | Base word address to read |
| cmd_wb_addr | input | 16 | Base word address for write-back |
| cmd_dst | input | 4 | Destination register index |
| sync_in | input | 32 | Synchronisation descriptor |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Command was rejected |
| done_wrote | output | 1 | Write-back was performed |
| seq_valid | output | 1 | Descriptor valid for the sequencer |
| seq_desc | output | 32 | Forwarded descriptor |
| gpr_rd_sel | input | 4 | Register read select |
| gpr_rd_data | output | 32 | Register read data |

## Verification
Each result has a fixed due cycle, counted from the accepting edge. The descriptor pulse is due in cycle 1. A rejected command completes in cycle 1. Reads occupy two cycles each, so the last data returns in cycle 2n, the write-backs fill cycles 2n+1 to 3n, and `done` follows in cycle 3n+1, or in cycle 2n+1 when the result is zero. The bench predicts this schedule and the exact order of accesses from its own memory image. On every falling edge it compares `mem_req`, `mem_we`, `mem_addr`, `mem_wdata`, `done` and `seq_valid` against that prediction, so an early, late, extra or missing event is reported in the cycle it occurs.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int SPM_DW     = 32;
    localparam int SPM_AW     = 16;
    localparam int SPM_MAXN   = 16;
    localparam int SPM_NGPR   = 16;
    localparam int SPM_SYNC_W = 32;

    typedef enum logic [1:0] {
        OP_MIN = 2'd0,
        OP_MAX = 2'd1,
        OP_ADD = 2'd2,
        OP_AND = 2'd3
    } spm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB,
        ST_FIN
    } spm_state_e;

    typedef struct packed {
        logic err;
        logic wrote;
    } spm_flags_t;

    function automatic logic [SPM_DW-1:0] spm_umin(input logic [SPM_DW-1:0] a,
                                                   input logic [SPM_DW-1:0] b);
        return (b < a) ? b : a;
    endfunction

    function automatic logic spm_op_ok(input logic [1:0] op);
        return op == OP_MIN;
    endfunction

endpackage

// File: rtl/spm_reduce.sv
module spm_reduce
    import spm_pkg::*;
#(
    parameter int DW = SPM_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          first,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] acc,
    output logic          acc_nz
);
    logic [DW-1:0] acc_next;

    always_comb begin
        if (first) acc_next = rdata;
        else       acc_next = spm_umin(acc, rdata);
    end

    // Nonzero test on the value being folded in, so the decision
    // needs no extra cycle after the last read.
    assign acc_nz = (acc_next != '0);

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (take) acc <= acc_next;
    end
endmodule

// File: rtl/spm_gpr.sv
module spm_gpr #(
    parameter int DW = 32,
    parameter int N  = 16,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] rsel,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                            regs[g] <= '0;
            else if (we && wsel == SW'(g))      regs[g] <= wdata;
        end
    end

    assign rdata = regs[rsel];
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
    import spm_pkg::*;
#(
    parameter int AW   = SPM_AW,
    parameter int MAXN = SPM_MAXN,
    localparam int CW  = $clog2(MAXN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] cmd_count,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cmd_wb_addr,
    input  logic          mem_rvalid,
    input  logic          acc_nz,
    output logic          accept,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          take,
    output logic          first,
    output logic          gpr_we,
    output logic          done,
    output spm_flags_t    flags
);
    spm_state_e    st;
    logic [CW-1:0] idx, n_q;
    logic [AW-1:0] base_q, wb_q;
    logic          err_q, nz_q;
    logic          bad, last;

    assign accept = start && (st == ST_IDLE);
    assign bad    = (cmd_count == '0) || (cmd_count > CW'(MAXN)) || !spm_op_ok(cmd_op);
    assign last   = (idx == n_q - CW'(1));
    assign take   = (st == ST_RD_WAIT) && mem_rvalid;
    assign first  = (idx == '0);
    assign gpr_we = take && last && acc_nz;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            n_q    <= '0;
            base_q <= '0;
            wb_q   <= '0;
            err_q  <= 1'b0;
            nz_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    n_q    <= cmd_count;
                    base_q <= cmd_addr;
                    wb_q   <= cmd_wb_addr;
                    idx    <= '0;
                    nz_q   <= 1'b0;
                    err_q  <= bad;
                    st     <= bad ? ST_FIN : ST_RD_REQ;
                end
                ST_RD_REQ: st <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) begin
                    if (last) begin
                        idx  <= '0;
                        nz_q <= acc_nz;
                        st   <= acc_nz ? ST_WB : ST_FIN;
                    end else begin
                        idx <= idx + CW'(1);
                        st  <= ST_RD_REQ;
                    end
                end
                ST_WB: begin
                    idx <= idx + CW'(1);
                    if (last) st <= ST_FIN;
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign mem_req  = (st == ST_RD_REQ) || (st == ST_WB);
    assign mem_we   = (st == ST_WB);
    assign mem_addr = ((st == ST_WB) ? wb_q : base_q) + AW'(idx);
    assign done     = (st == ST_FIN);
    assign flags    = '{err: err_q, wrote: nz_q};
endmodule

// File: rtl/sem_poll_minred.sv
module sem_poll_minred
    import spm_pkg::*;
#(
    parameter int DW     = SPM_DW,
    parameter int AW     = SPM_AW,
    parameter int MAXN   = SPM_MAXN,
    parameter int NGPR   = SPM_NGPR,
    parameter int SYNC_W = SPM_SYNC_W,
    localparam int CW    = $clog2(MAXN + 1),
    localparam int GSW   = (NGPR > 1) ? $clog2(NGPR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CW-1:0]     cmd_count,
    input  logic [1:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [AW-1:0]     cmd_wb_addr,
    input  logic [GSW-1:0]    cmd_dst,
    input  logic [SYNC_W-1:0] sync_in,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_rvalid,
    output logic              done,
    output logic              done_err,
    output logic              done_wrote,
    output logic              seq_valid,
    output logic [SYNC_W-1:0] seq_desc,
    input  logic [GSW-1:0]    gpr_rd_sel,
    output logic [DW-1:0]     gpr_rd_data
);
    logic          accept, take, first, gpr_we, acc_nz;
    logic [DW-1:0] acc;
    logic [GSW-1:0] dst_q;
    spm_flags_t    flags;

    spm_ctrl #(.AW(AW), .MAXN(MAXN)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .cmd_count(cmd_count), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wb_addr(cmd_wb_addr),
        .mem_rvalid(mem_rvalid), .acc_nz(acc_nz),
        .accept(accept), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .take(take), .first(first), .gpr_we(gpr_we),
        .done(done), .flags(flags)
    );

    spm_reduce #(.DW(DW)) u_red (
        .clk(clk), .rst(rst), .take(take), .first(first),
        .rdata(mem_rdata), .acc(acc), .acc_nz(acc_nz)
    );

    spm_gpr #(.DW(DW), .N(NGPR)) u_gpr (
        .clk(clk), .rst(rst), .we(gpr_we), .wsel(dst_q),
        .wdata(mem_rdata < acc || first ? (first ? mem_rdata : spm_umin(acc, mem_rdata)) : acc),
        .rsel(gpr_rd_sel), .rdata(gpr_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q     <= '0;
            seq_valid <= 1'b0;
            seq_desc  <= '0;
        end else begin
            seq_valid <= accept;
            if (accept) begin
                dst_q    <= cmd_dst;
                seq_desc <= sync_in;
            end
        end
    end

    assign mem_wdata  = acc;
    assign done_err   = flags.err;
    assign done_wrote = flags.wrote;
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
    parameter int CW     = 5,
    parameter int SYNC_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic [CW-1:0]     cmd_count,
    input logic [SYNC_W-1:0] sync_in,
    input logic              mem_req,
    input logic              mem_we,
    input logic              done,
    input logic              done_err,
    input logic              done_wrote,
    input logic              seq_valid,
    input logic [SYNC_W-1:0] seq_desc
);
    logic          acc_ok;
    logic          wrote_seen;
    logic [CW-1:0] n_lat;
    logic [7:0]    acc_cnt, wr_cnt;

    assign acc_ok = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wrote_seen <= 1'b0;
            n_lat      <= '0;
            acc_cnt    <= '0;
            wr_cnt     <= '0;
        end else if (acc_ok) begin
            wrote_seen <= 1'b0;
            n_lat      <= cmd_count;
            acc_cnt    <= '0;
            wr_cnt     <= '0;
        end else begin
            if (mem_req)           acc_cnt <= acc_cnt + 8'd1;
            if (mem_req && mem_we) begin
                wr_cnt     <= wr_cnt + 8'd1;
                wrote_seen <= 1'b1;
            end
        end
    end

    assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);

    assert_reads_before_writes_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !wrote_seen);

    assert_reject_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> (acc_cnt == 8'd0 && !done_wrote));

    assert_zero_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !done_wrote) |-> (wr_cnt == 8'd0));

    assert_wb_count_R5: assert property (@(posedge clk) disable iff (rst)
        (done && done_wrote) |-> (wr_cnt == 8'(n_lat)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_sync_forward_R10: assert property (@(posedge clk) disable iff (rst)
        acc_ok |=> (seq_valid && seq_desc == $past(sync_in)));

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !seq_valid);
endmodule

bind sem_poll_minred spm_checker #(.CW(CW), .SYNC_W(SYNC_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .cmd_count(cmd_count), .sync_in(sync_in),
    .mem_req(mem_req), .mem_we(mem_we),
    .done(done), .done_err(done_err), .done_wrote(done_wrote),
    .seq_valid(seq_valid), .seq_desc(seq_desc)
);

// File: tb/sim_sem_poll_minred.sv
`timescale 1ns/1ps
module sim_sem_poll_minred;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  cmd_count;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_addr, cmd_wb_addr;
    logic [3:0]  cmd_dst;
    logic [31:0] sync_in;
    logic        busy, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_rvalid;
    logic        done, done_err, done_wrote, seq_valid;
    logic [31:0] seq_desc;
    logic [3:0]  gpr_rd_sel;
    logic [31:0] gpr_rd_data;

    always #2 clk = ~clk;

    sem_poll_minred u0 (
        .clk(clk), .rst(rst), .start(start), .cmd_count(cmd_count), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wb_addr(cmd_wb_addr), .cmd_dst(cmd_dst), .sync_in(sync_in),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .done(done), .done_err(done_err), .done_wrote(done_wrote),
        .seq_valid(seq_valid), .seq_desc(seq_desc),
        .gpr_rd_sel(gpr_rd_sel), .gpr_rd_data(gpr_rd_data)
    );

    // Memory with one-cycle read latency and a preload port
    logic [31:0] mem [256];
    logic        ld_en;
    logic [7:0]  ld_addr;
    logic [31:0] ld_data;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (ld_en) mem[ld_addr] <= ld_data;
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:0]];
            end
        end
    end

    // Reference state
    logic [31:0] ref_mem [256];
    logic [31:0] ref_gpr [16];
    bit          q_we   [$];
    logic [15:0] q_addr [$];
    logic [31:0] q_wd   [$];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'(a); ld_data = v;
        ref_mem[a] = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input string tag, input int n, input logic [1:0] op, input int a,
                       input int wb, input int sel, input logic [31:0] sy, input bit dbl);
        bit          bad, nz;
        logic [31:0] m;
        int          exp_done;
        bad = (n == 0) || (n > 16) || (op != 2'd0);
        nz  = 1'b0;
        m   = '0;
        q_we.delete(); q_addr.delete(); q_wd.delete();
        if (!bad) begin
            m = ref_mem[a % 256];
            for (int i = 0; i < n; i++) begin
                if (ref_mem[(a + i) % 256] < m) m = ref_mem[(a + i) % 256];
                q_we.push_back(1'b0); q_addr.push_back(16'(a + i)); q_wd.push_back('0);
            end
            nz = (m != 0);
            if (nz) for (int i = 0; i < n; i++) begin
                q_we.push_back(1'b1); q_addr.push_back(16'(wb + i)); q_wd.push_back(m);
            end
            exp_done = nz ? 3 * n + 1 : 2 * n + 1;
        end else begin
            exp_done = 1;
        end

        @(negedge clk);
        start = 1'b1; cmd_count = 5'(n); cmd_op = op; cmd_addr = 16'(a);
        cmd_wb_addr = 16'(wb); cmd_dst = 4'(sel); sync_in = sy;
        for (int cyc = 1; cyc <= exp_done + 2; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (dbl && cyc == 3) begin
                start = 1'b1; sync_in = ~sy; cmd_addr = 16'hA0; cmd_count = 5'd1;
            end
            if (mem_req) begin
                if (q_we.size() == 0) begin
                    chk(1'b0, bad ? "R3" : "R1", {tag, " unexpected access"}, 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    bit          w;
                    logic [15:0] ea;
                    logic [31:0] ed;
                    w = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_wd.pop_front();
                    chk(mem_we == w, w ? "R5" : "R1", {tag, " access kind"}, 32'(mem_we), 32'(w));
                    chk(mem_addr == ea, w ? "R5" : "R1", {tag, " access address"}, 32'(mem_addr), 32'(ea));
                    if (w) chk(mem_wdata == ed, "R4", {tag, " write-back value"}, mem_wdata, ed);
                end
            end
            chk(done == (cyc == exp_done), "R8", {tag, " done timing"}, 32'(done), 32'(cyc == exp_done));
            if (cyc == exp_done) begin
                chk(done_err == bad, bad ? "R2" : "R3", {tag, " error flag"}, 32'(done_err), 32'(bad));
                chk(done_wrote == nz, "R7", {tag, " wrote flag"}, 32'(done_wrote), 32'(nz));
            end
            chk(seq_valid == (cyc == 1), dbl ? "R9" : "R10", {tag, " descriptor strobe"},
                32'(seq_valid), 32'(cyc == 1));
            if (cyc == 1) chk(seq_desc == sy, "R10", {tag, " descriptor value"}, seq_desc, sy);
        end
        chk(q_we.size() == 0, "R5", {tag, " missing accesses"}, 32'(q_we.size()), 0);

        if (nz) begin
            for (int i = 0; i < n; i++) ref_mem[(wb + i) % 256] = m;
            ref_gpr[sel] = m;
        end
        gpr_rd_sel = 4'(sel);
        #1;
        chk(gpr_rd_data == ref_gpr[sel], nz ? "R6" : "R7", {tag, " register"}, gpr_rd_data, ref_gpr[sel]);
        if (!bad) for (int i = 0; i < n; i++)
            chk(mem[(wb + i) % 256] == ref_mem[(wb + i) % 256], nz ? "R5" : "R7",
                {tag, " memory image"}, mem[(wb + i) % 256], ref_mem[(wb + i) % 256]);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        checks++; errors++;
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 32'd77; ref_mem[i] = 32'd77; end
        for (int i = 0; i < 16; i++) ref_gpr[i] = '0;
        rst = 1'b1; start = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        cmd_count = '0; cmd_op = '0; cmd_addr = '0; cmd_wb_addr = '0; cmd_dst = '0;
        sync_in = '0; gpr_rd_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11", "busy after reset", 32'(busy), 0);
        chk(!mem_req, "R11", "mem_req after reset", 32'(mem_req), 0);
        chk(!done && !seq_valid, "R11", "strobes after reset", 32'({done, seq_valid}), 0);
        for (int i = 0; i < 16; i++) begin
            gpr_rd_sel = 4'(i); #1;
            chk(gpr_rd_data == 0, "R11", "register after reset", gpr_rd_data, 0);
        end

        // R4 basic minimum, in-place write-back
        put_word(16'h10, 9); put_word(16'h11, 5); put_word(16'h12, 7); put_word(16'h13, 12);
        run("R4 basic", 4, 2'd0, 16'h10, 16'h10, 3, 32'h1234_5678, 1'b0);

        // R9 start while busy is ignored
        put_word(16'h20, 30); put_word(16'h21, 20); put_word(16'h22, 25);
        run("R9 busy start", 3, 2'd0, 16'h20, 16'h20, 4, 32'hCAFE_0001, 1'b1);

        // R5 single word, separate write-back base
        put_word(16'h30, 42);
        run("R5 single", 1, 2'd0, 16'h30, 16'h60, 5, 32'h0000_0005, 1'b0);

        // R1 full 16-word group
        for (int i = 0; i < 16; i++) put_word(16'h80 + i, (i == 11) ? 32'd3 : 32'(1000 - 7 * i));
        run("R1 sixteen", 16, 2'd0, 16'h80, 16'h80, 6, 32'hA5A5_A5A5, 1'b0);

        // R7 zero minimum: no write-back, register 3 keeps 5
        put_word(16'h40, 8); put_word(16'h41, 0); put_word(16'h42, 9);
        put_word(16'h43, 4); put_word(16'h44, 6);
        run("R7 zero", 5, 2'd0, 16'h40, 16'h40, 3, 32'h0000_0707, 1'b0);

        // R4 unsigned compare
        put_word(16'h50, 32'hFFFF_FFFF); put_word(16'h51, 32'h8000_0000);
        run("R4 unsigned", 2, 2'd0, 16'h50, 16'h50, 7, 32'h0000_0050, 1'b0);

        // R4 first word is the minimum (seed)
        put_word(16'h58, 2); put_word(16'h59, 9); put_word(16'h5A, 9);
        run("R4 seed", 3, 2'd0, 16'h58, 16'h58, 8, 32'h0000_0058, 1'b0);

        // R2 other operation codes rejected
        run("R2 op1", 4, 2'd1, 16'h10, 16'h10, 9, 32'h0000_0201, 1'b0);
        run("R2 op3", 4, 2'd3, 16'h10, 16'h10, 9, 32'h0000_0203, 1'b0);

        // R3 count out of range
        run("R3 zero count", 0, 2'd0, 16'h10, 16'h10, 10, 32'h0000_0300, 1'b0);
        run("R3 count17", 17, 2'd0, 16'h10, 16'h10, 10, 32'h0000_0317, 1'b0);

        // R7 sixteen words with zero in last position
        for (int i = 0; i < 16; i++) put_word(16'hC0 + i, (i == 15) ? 32'd0 : 32'(50 + i));
        run("R7 zero last", 16, 2'd0, 16'hC0, 16'hC0, 11, 32'h0000_0C0C, 1'b0);

        summary();
        $finish;
    end
endmodule